// File: doc/BRIEF.md
# Triggered Double-Bank Sample Snapshot Buffer

This block records a free-running stream of converter samples into one of two circular sample banks. Each bank holds 1024 entries. While no snapshot is held, the live bank acts as a sliding window of recent history. Each new sample goes in at that bank's write pointer, and once the pointer has wrapped, the new sample overwrites the oldest one. Samples are never dropped because nothing has read them.

When a trigger is accepted, the live bank is frozen as a snapshot and capture moves to the other bank. A ready flag then tells the host that a snapshot can be drained. The host pulls samples one at a time with an asynchronous read strobe. It may begin at any time after the flag rises and may read at any rate. The read order runs from oldest to newest.

The sample strobe and the host read strobe both enter one fast master clock through synchronizers. Each strobe becomes a single-cycle enable there, and select logic decides which bank pointer that enable moves. No strobe ever clocks a memory directly. The master clock must be fast enough that every strobe stays high and low for at least two of its periods.

Top module: `snap_capture_buf`

## Requirements
- R1: Each rising edge of `smp_strobe` or `rd_strobe` causes exactly one action, however long the strobe stays high. The action takes effect on the third master-clock rising edge counted from the first edge that samples the strobe high: two synchronizer flops, then the acting edge.
- R2: A sample action writes `smp_data` into the live bank only, at that bank's write pointer, and advances the pointer. The pointer wraps from 1023 to 0, so the newest sample replaces the oldest.
- R3: A trigger that is high at a clock edge while `data_rdy` is low does three things at that edge: it swaps the roles of the two banks, it sets `data_rdy`, and it starts a new snapshot. `data_rdy` is high after that same edge.
- R4: The first read of a snapshot returns the oldest sample in the frozen bank, which is the entry at the bank's write pointer as it stood when frozen. Each later read returns the next entry in circular order. `rd_data` changes only at the edge that performs a read action.
- R5: The edge that performs the 1024th read of a snapshot clears `data_rdy`. After that edge the next trigger is accepted again.
- R6: A trigger seen while `data_rdy` is high is ignored. The bank roles do not change, and the read sequence continues within the same snapshot.
- R7: A read action while `data_rdy` is low is ignored. `rd_data` holds its value and no read pointer moves.
- R8: A sample action at the same edge as an accepted trigger is written into the bank being frozen. It becomes the newest entry of that snapshot.
- R9: Synchronous reset clears both write pointers and the read pointer, makes bank 0 live, clears `data_rdy` and arms the trigger.
- R10: Sample actions keep filling the live bank while the host drains the snapshot, including on the same edges as read actions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, runs all logic |
| rst | input | 1 | Synchronous active-high reset |
| smp_strobe | input | 1 | Asynchronous sample-valid strobe derived from the converter clock |
| smp_data | input | DATA_W | Sample value, held stable around its strobe |
| rd_strobe | input | 1 | Asynchronous host read strobe |
| trig | input | 1 | Capture trigger, synchronous to `clk` |
| data_rdy | output | 1 | A snapshot is frozen and not yet fully read |
| rd_data | output | DATA_W | Most recently read snapshot sample |

## Verification
The results fall due at different times. A strobe that is first sampled high at edge k acts at edge k+2. So a read result appears on `rd_data` just after that edge, and a sample lands in memory at that edge. A trigger changes `data_rdy` at the very edge where it is seen. The bench's model advances its own pair of synchronizer bits at every rising edge, so it applies each action at the same edge the design should. Both outputs are compared at the following falling edge, and the directed checks read the outputs only after the acting edge has passed.

// File: rtl/snap_pkg.sv
`timescale 1ns/1ps
package snap_pkg;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

  function automatic bank_e other_bank(input bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction
endpackage

// File: rtl/strobe_sync.sv
`timescale 1ns/1ps
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic pulse
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[STAGES-1:0], async_in};
  end

  assign pulse = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/sample_ram.sv
`timescale 1ns/1ps
module sample_ram #(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/snap_ctrl.sv
`timescale 1ns/1ps
module snap_ctrl
  import snap_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  smp_pulse,
  input  logic                  rd_pulse,
  input  logic                  trig,
  output logic [1:0]            bank_we,
  output logic [1:0][ADDR_W-1:0] bank_waddr,
  output logic [1:0]            bank_re,
  output logic [ADDR_W-1:0]     rptr,
  output bank_e                 live,
  output bank_e                 rd_sel,
  output logic                  ready
);
  logic [1:0][ADDR_W-1:0] wptr;
  logic [ADDR_W-1:0]      rcnt;
  logic [ADDR_W-1:0]      wptr_next;
  logic                   rd_go;
  logic                   trig_go;

  assign rd_go   = rd_pulse & ready;
  assign trig_go = trig & ~ready;

  // live write pointer after this edge's sample (if any)
  always_comb begin
    wptr_next = wptr[live];
    if (smp_pulse) wptr_next = wptr[live] + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      rcnt   <= '0;
      live   <= BANK_A;
      rd_sel <= BANK_A;
      ready  <= 1'b0;
    end else begin
      if (smp_pulse) wptr[live] <= wptr_next;
      if (rd_go) begin
        rptr   <= rptr + 1'b1;
        rcnt   <= rcnt + 1'b1;
        rd_sel <= other_bank(live);
        if (rcnt == '1) ready <= 1'b0;
      end
      if (trig_go) begin
        live  <= other_bank(live);
        rptr  <= wptr_next;
        rcnt  <= '0;
        ready <= 1'b1;
      end
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_sel
    assign bank_we[b]    = smp_pulse & (live == bank_e'(b));
    assign bank_re[b]    = rd_go & (live != bank_e'(b));
    assign bank_waddr[b] = wptr[b];
  end
endmodule

// File: rtl/snap_capture_buf.sv
`timescale 1ns/1ps
module snap_capture_buf
  import snap_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int ADDR_W    = 10,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_strobe,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              rd_strobe,
  input  logic              trig,
  output logic              data_rdy,
  output logic [DATA_W-1:0] rd_data
);
  logic                   smp_pulse;
  logic                   rd_pulse;
  logic [1:0]             bank_we;
  logic [1:0]             bank_re;
  logic [1:0][ADDR_W-1:0] bank_waddr;
  logic [ADDR_W-1:0]      rptr;
  bank_e                  live_sel;
  bank_e                  rd_sel;
  logic [DATA_W-1:0]      bank_q [2];

  strobe_sync #(.STAGES(SYNC_STGS)) u_smp_sync (
    .clk(clk), .rst(rst), .async_in(smp_strobe), .pulse(smp_pulse)
  );

  strobe_sync #(.STAGES(SYNC_STGS)) u_rd_sync (
    .clk(clk), .rst(rst), .async_in(rd_strobe), .pulse(rd_pulse)
  );

  snap_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .smp_pulse(smp_pulse), .rd_pulse(rd_pulse), .trig(trig),
    .bank_we(bank_we), .bank_waddr(bank_waddr), .bank_re(bank_re),
    .rptr(rptr), .live(live_sel), .rd_sel(rd_sel), .ready(data_rdy)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    sample_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .clk(clk),
      .we(bank_we[b]), .waddr(bank_waddr[b]), .wdata(smp_data),
      .re(bank_re[b]), .raddr(rptr), .rdata(bank_q[b])
    );
  end

  // both sources are registers; rd_sel moves only on a read
  assign rd_data = bank_q[rd_sel];
endmodule

// File: rtl/snap_capture_buf_chk.sv
`timescale 1ns/1ps
module snap_capture_buf_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              trig,
  input logic              data_rdy,
  input logic [DATA_W-1:0] rd_data,
  input logic              smp_pulse,
  input logic              rd_pulse,
  input logic              live_sel
);
  // R1: one strobe edge gives a single-cycle enable
  a_r1_smp_single: assert property (@(posedge clk) disable iff (rst)
    smp_pulse |=> !smp_pulse);
  a_r1_rd_single: assert property (@(posedge clk) disable iff (rst)
    rd_pulse |=> !rd_pulse);

  // R3: accepted trigger sets ready and swaps banks
  a_r3_rdy_set: assert property (@(posedge clk) disable iff (rst)
    (trig && !data_rdy) |=> data_rdy);
  a_r3_swap: assert property (@(posedge clk) disable iff (rst)
    (trig && !data_rdy) |=> (live_sel != $past(live_sel)));

  // R6: trigger while a snapshot is held changes nothing
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (rst)
    data_rdy |=> $stable(live_sel));

  // R5: ready falls only after a read action
  a_r5_fall_on_read: assert property (@(posedge clk) disable iff (rst)
    $fell(data_rdy) |-> $past(rd_pulse));

  // R4 / R7: output moves only on a performed read
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !(rd_pulse && data_rdy) |=> $stable(rd_data));

  // R9: reset state
  a_r9_reset: assert property (@(posedge clk)
    rst |=> (!data_rdy && !live_sel));
endmodule

bind snap_capture_buf snap_capture_buf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .trig(trig), .data_rdy(data_rdy), .rd_data(rd_data),
  .smp_pulse(smp_pulse), .rd_pulse(rd_pulse), .live_sel(live_sel)
);

// File: tb/snap_capture_buf_tb.sv
`timescale 1ns/1ps
module snap_capture_buf_tb;
  localparam int DW = 12;
  localparam int DEPTH = 1024;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_strobe = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic          rd_strobe = 1'b0;
  logic          trig = 1'b0;
  logic          data_rdy;
  logic [DW-1:0] rd_data;

  int n_chk = 0;
  int n_err = 0;
  int ns = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  snap_capture_buf #(.DATA_W(DW), .ADDR_W(10)) u_dut (
    .clk(clk), .rst(rst), .smp_strobe(smp_strobe), .smp_data(smp_data),
    .rd_strobe(rd_strobe), .trig(trig), .data_rdy(data_rdy), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] val(input int i);
    return DW'((i * 37 + 5) & ((1 << DW) - 1));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  mem [2][DEPTH];
  bit  vld [2][DEPTH];
  int  wp [2];
  int  m_rp, m_rc, m_live;
  bit  m_rdy;
  bit  ms1, ms2, ms3, mr1, mr2, mr3;
  int  exp_rd;
  bit  exp_ok;

  always @(posedge clk) begin
    bit sp, rp, rdy0;
    if (rst) begin
      wp[0] = 0; wp[1] = 0; m_rp = 0; m_rc = 0; m_live = 0; m_rdy = 0;
      ms1 = 0; ms2 = 0; ms3 = 0; mr1 = 0; mr2 = 0; mr3 = 0;
    end else begin
      sp = ms2 & ~ms3;
      rp = mr2 & ~mr3;
      ms3 = ms2; ms2 = ms1; ms1 = smp_strobe;
      mr3 = mr2; mr2 = mr1; mr1 = rd_strobe;
      rdy0 = m_rdy;
      if (sp) begin
        mem[m_live][wp[m_live]] = int'(smp_data);
        vld[m_live][wp[m_live]] = 1'b1;
        wp[m_live] = (wp[m_live] + 1) % DEPTH;
      end
      if (rp && rdy0) begin
        exp_rd = mem[1-m_live][m_rp];
        exp_ok = vld[1-m_live][m_rp];
        m_rp = (m_rp + 1) % DEPTH;
        m_rc++;
        if (m_rc == DEPTH) begin m_rdy = 0; m_rc = 0; end
      end
      if (trig && !rdy0) begin
        m_rp = wp[m_live];
        m_live = 1 - m_live;
        m_rdy = 1;
        m_rc = 0;
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk("R3 ready flag", 32'(data_rdy), 32'(m_rdy));
      if (exp_ok) chk("R4 R10 read data", 32'(rd_data), 32'(exp_rd));
    end
    if (cyc > 150000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic strobe(input bit s, input bit r, input int hi, input int lo);
    if (s) begin smp_data = val(ns); ns++; end
    smp_strobe = s; rd_strobe = r;
    repeat (hi) @(negedge clk);
    smp_strobe = 1'b0; rd_strobe = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  // sample whose acting edge coincides with the trigger
  task automatic sample_with_trig();
    smp_data = val(ns); ns++;
    smp_strobe = 1'b1;
    @(negedge clk);
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    smp_strobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_trig();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] held;
    exp_ok = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 reset ready low", 32'(data_rdy), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // fill past one wrap of bank 0
    for (int i = 0; i < 1100; i++) strobe(1, 0, 3, 3);
    chk("R9 no ready without trigger", 32'(data_rdy), 32'd0);
    sample_with_trig();
    chk("R3 ready after trigger", 32'(data_rdy), 32'd1);

    strobe(0, 1, 3, 3);
    chk("R2 R4 first read is oldest", 32'(rd_data), 32'(val(77)));
    for (int i = 1; i < 10; i++) strobe(0, 1, 3, 3);

    pulse_trig();
    chk("R6 ready still high", 32'(data_rdy), 32'd1);
    strobe(0, 1, 3, 3);
    chk("R6 same snapshot continues", 32'(rd_data), 32'(val(87)));

    for (int i = 0; i < 30; i++) strobe(1, 1, 3, 3);
    for (int i = 0; i < 983; i++) strobe(0, 1, 3, 3);
    chk("R8 newest is trigger-cycle sample", 32'(rd_data), 32'(val(1100)));
    chk("R5 ready cleared after last read", 32'(data_rdy), 32'd0);

    held = rd_data;
    strobe(0, 1, 3, 3);
    chk("R7 read ignored when not ready", 32'(rd_data), 32'(held));
    chk("R7 ready stays low", 32'(data_rdy), 32'd0);

    // long strobes: one write each
    for (int i = 0; i < 50; i++) strobe(1, 0, 10, 3);
    pulse_trig();
    chk("R5 trigger re-armed", 32'(data_rdy), 32'd1);
    for (int i = 1; i <= 1024; i++) begin
      strobe(0, 1, 3, 3);
      if (i == 945)
        chk("R10 sample taken during reads", 32'(rd_data), 32'(val(1101)));
    end
    chk("R1 one write per long strobe", 32'(rd_data), 32'(val(1180)));
    chk("R5 ready cleared again", 32'(data_rdy), 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule